// File: doc/BRIEF.md
# CAN controller mode sequencer and timing register block

This block is the control-plane front end of a CAN controller. Software reaches it through a 32-bit register port addressed by byte offset. Through that port it programs the baud-rate prescaler and the bit-timing fields, selects loopback or sleep operation, and starts or stops the core. The block holds these settings and tracks the core's operating mode. It also drives the stored timing fields straight to the bit-timing engine, which lives outside this block.

The mode sequencer runs five states: configuration, normal, loopback, sleep and bus-off. The core starts in configuration, and timing can only be changed in that state. An enable write starts the core in the requested mode after a fixed delay. A mode-select write can put a running core to sleep, and the wake input brings it back to the mode it left. The bus-off input parks a running or sleeping core in bus-off. A soft-reset write is the single path back to configuration from every state, bus-off included.

Reads are combinational on the address. The status word always has exactly one mode bit set, and after reset it reads exactly 0x00000001, so software can use it to detect byte order.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the status word at offset 0x18 reads exactly 0x00000001, `modeCfg` is high, and the prescaler and all timing field outputs are zero.
- R2: The status word carries configuration in bit 0, loopback in bit 1, sleep in bit 2, normal in bit 3 and bus-off in bit 4. Exactly one of these bits is set at any time, and the five mode outputs mirror the same bits.
- R3: In configuration mode a write to offset 0x08 stores bits [7:0] as the prescaler (divide value minus one). A write to offset 0x0C stores segment 1 from bits [3:0], segment 2 from bits [6:4] and jump width from bits [8:7], each held minus one. Both take effect on the outputs and on readback in the cycle after the write.
- R4: Writes to offsets 0x08 and 0x0C are ignored while the core is in any mode other than configuration; the outputs and the readback keep their old values.
- R5: In configuration mode, a write to offset 0x00 with bit 1 set and bit 0 clear moves the core exactly two clocks later. It goes to loopback if mode-select bit 1 was set at the time of the write, and to normal otherwise. The status shows configuration until that clock.
- R6: A write to offset 0x00 with bit 0 set returns the core to configuration on the next clock from any mode. The same write clears the enable flag and the mode-select register, cancels a pending start, and overrides bit 1 of the same write. Prescaler and timing values are kept.
- R7: In normal or loopback mode, a write to offset 0x04 with bit 0 set enters sleep on the next clock.
- R8: In sleep, a high `wakeIn` returns the core on the next clock to the mode it was in before sleeping. In any other mode `wakeIn` has no effect.
- R9: A high `busOff` in normal, loopback or sleep enters bus-off on the next clock, and it is ignored in configuration. Bus-off is left only through soft reset, and enable writes there have no effect.
- R10: Offset 0x00 reads the enable flag in bit 1, and offset 0x04 reads the mode-select bits [1:0]. Unused bits and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| busOff | input | 1 | Bus-off indication from the error logic |
| wakeIn | input | 1 | Wake request while sleeping |
| modeCfg | output | 1 | Core is in configuration mode |
| modeNorm | output | 1 | Core is in normal mode |
| modeLoop | output | 1 | Core is in loopback mode |
| modeSleep | output | 1 | Core is asleep |
| modeBusOff | output | 1 | Core is in bus-off |
| brpOut | output | 8 | Stored prescaler (divide minus one) |
| tseg1Out | output | 4 | Stored time segment 1 minus one |
| tseg2Out | output | 3 | Stored time segment 2 minus one |
| sjwOut | output | 2 | Stored jump width minus one |

## Verification
The bench builds the block with its defaults: a start delay of two clocks, an 8-bit prescaler and 4/3/2-bit timing fields. With this delay both intermediate configuration cycles of a start can be seen, and a soft reset can land inside the start window to cancel it. The full field widths let all-ones writes show that bits above bit 8 of the timing word and above bit 7 of the prescaler are dropped. A behavioural model follows every state on every clock, including the return from sleep to loopback and bus-off entered from sleep.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    M_CFG   = 3'd0,
    M_NORM  = 3'd1,
    M_LOOP  = 3'd2,
    M_SLEEP = 3'd3,
    M_BOFF  = 3'd4
  } opMode_e;

  // register decode strobes handed from the datapath to the sequencer
  typedef struct packed {
    logic rstReq;
    logic enReq;
    logic sleepReq;
    logic loopSel;
  } decStrobe_t;

  // sequencer state strobes handed back to the datapath
  typedef struct packed {
    logic cfgOpen;
    logic inLoop;
    logic inNorm;
    logic inSleep;
    logic inBoff;
  } ctrlStrobe_t;

  localparam int OFS_CTL   = 'h00;
  localparam int OFS_MODE  = 'h04;
  localparam int OFS_PRESC = 'h08;
  localparam int OFS_TIME  = 'h0C;
  localparam int OFS_STAT  = 'h18;

  localparam int ST_CFG   = 0;
  localparam int ST_LOOP  = 1;
  localparam int ST_SLEEP = 2;
  localparam int ST_NORM  = 3;
  localparam int ST_BOFF  = 4;

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PRESC_W = 8,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         wrData,
  input  ctrlStrobe_t         ctrl,
  output decStrobe_t          dec,
  output logic [31:0]         rdData,
  output logic [PRESC_W-1:0]  presc,
  output logic [TS1_W-1:0]    ts1,
  output logic [TS2_W-1:0]    ts2,
  output logic [SJW_W-1:0]    sjw
);

  localparam int TIME_W  = TS1_W + TS2_W + SJW_W;
  localparam int TS2_LSB = TS1_W;
  localparam int SJW_LSB = TS1_W + TS2_W;

  logic              hitCtl, hitMode, hitPresc, hitTime, hitStat;
  logic              enFlag;
  logic [1:0]        modeSel;
  logic [TIME_W-1:0] timing;
  logic [31:0]       statusWord;
  logic              unusedWrBits;

  assign hitCtl   = (regAddr == ADDR_W'(OFS_CTL));
  assign hitMode  = (regAddr == ADDR_W'(OFS_MODE));
  assign hitPresc = (regAddr == ADDR_W'(OFS_PRESC));
  assign hitTime  = (regAddr == ADDR_W'(OFS_TIME));
  assign hitStat  = (regAddr == ADDR_W'(OFS_STAT));
  assign unusedWrBits = ^wrData[31:TIME_W];

  assign dec.rstReq   = wrEn && hitCtl && wrData[0];
  assign dec.enReq    = wrEn && hitCtl && wrData[1] && !wrData[0];
  assign dec.sleepReq = wrEn && hitMode && wrData[0];
  assign dec.loopSel  = modeSel[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enFlag  <= 1'b0;
      modeSel <= 2'b00;
      presc   <= '0;
      timing  <= '0;
    end else begin
      if (dec.rstReq) begin
        enFlag  <= 1'b0;
        modeSel <= 2'b00;
      end else if (wrEn && hitCtl) begin
        enFlag <= wrData[1];
      end
      if (wrEn && hitMode)
        modeSel <= wrData[1:0];
      if (wrEn && hitPresc && ctrl.cfgOpen)
        presc <= wrData[PRESC_W-1:0];
      if (wrEn && hitTime && ctrl.cfgOpen)
        timing <= wrData[TIME_W-1:0];
    end
  end

  assign ts1 = timing[TS1_W-1:0];
  assign ts2 = timing[TS2_LSB +: TS2_W];
  assign sjw = timing[SJW_LSB +: SJW_W];

  always_comb begin
    statusWord           = '0;
    statusWord[ST_CFG]   = ctrl.cfgOpen;
    statusWord[ST_LOOP]  = ctrl.inLoop;
    statusWord[ST_SLEEP] = ctrl.inSleep;
    statusWord[ST_NORM]  = ctrl.inNorm;
    statusWord[ST_BOFF]  = ctrl.inBoff;
  end

  always_comb begin
    rdData = '0;
    if (hitCtl)        rdData[1]          = enFlag;
    else if (hitMode)  rdData[1:0]        = modeSel;
    else if (hitPresc) rdData[PRESC_W-1:0] = presc;
    else if (hitTime)  rdData[TIME_W-1:0] = timing;
    else if (hitStat)  rdData             = statusWord;
  end

  // R4: timing storage frozen whenever the sequencer is outside configuration
  a_r4_timing_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.cfgOpen |=> ($stable(presc) && $stable(timing)));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int START_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  decStrobe_t  dec,
  input  logic        busOff,
  input  logic        wakeIn,
  output ctrlStrobe_t ctrl
);

  localparam int CNT_W = (START_DELAY < 2) ? 1 : $clog2(START_DELAY);

  opMode_e          state, prior, target;
  logic             armed;
  logic [CNT_W-1:0] armCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= M_CFG;
      prior  <= M_NORM;
      target <= M_NORM;
      armed  <= 1'b0;
      armCnt <= '0;
    end else if (dec.rstReq) begin
      state <= M_CFG;
      armed <= 1'b0;
    end else begin
      case (state)
        M_CFG: begin
          if (armed) begin
            if (armCnt == '0) begin
              state <= target;
              armed <= 1'b0;
            end else begin
              armCnt <= armCnt - 1'b1;
            end
          end else if (dec.enReq) begin
            armed  <= 1'b1;
            armCnt <= CNT_W'(START_DELAY - 1);
            target <= dec.loopSel ? M_LOOP : M_NORM;
          end
        end
        M_NORM, M_LOOP: begin
          if (busOff) begin
            state <= M_BOFF;
          end else if (dec.sleepReq) begin
            prior <= state;
            state <= M_SLEEP;
          end
        end
        M_SLEEP: begin
          if (busOff)      state <= M_BOFF;
          else if (wakeIn) state <= prior;
        end
        default: ;
      endcase
    end
  end

  assign ctrl.cfgOpen = (state == M_CFG);
  assign ctrl.inNorm  = (state == M_NORM);
  assign ctrl.inLoop  = (state == M_LOOP);
  assign ctrl.inSleep = (state == M_SLEEP);
  assign ctrl.inBoff  = (state == M_BOFF);

  // R5: the cycle after an accepted enable the core is still configuring
  a_r5_start_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_CFG && !armed && dec.enReq && !dec.rstReq) |=> (state == M_CFG && armed));

  // R6: soft reset always lands in configuration with no start pending
  a_r6_reset_to_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rstReq |=> (state == M_CFG && !armed));

  // R8: wake restores the mode held before sleeping
  a_r8_wake_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_SLEEP && wakeIn && !busOff && !dec.rstReq) |=> (state == $past(prior)));

  // R9: bus-off holds until soft reset
  a_r9_busoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_BOFF && !dec.rstReq) |=> (state == M_BOFF));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PRESC_W     = 8,
  parameter int TS1_W       = 4,
  parameter int TS2_W       = 3,
  parameter int SJW_W       = 2,
  parameter int START_DELAY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic               busOff,
  input  logic               wakeIn,
  output logic               modeCfg,
  output logic               modeNorm,
  output logic               modeLoop,
  output logic               modeSleep,
  output logic               modeBusOff,
  output logic [PRESC_W-1:0] brpOut,
  output logic [TS1_W-1:0]   tseg1Out,
  output logic [TS2_W-1:0]   tseg2Out,
  output logic [SJW_W-1:0]   sjwOut
);

  decStrobe_t  dec;
  ctrlStrobe_t ctrl;

  can_mode_regs #(
    .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .ctrl(ctrl), .dec(dec), .rdData(rdData),
    .presc(brpOut), .ts1(tseg1Out), .ts2(tseg2Out), .sjw(sjwOut)
  );

  can_mode_fsm #(.START_DELAY(START_DELAY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dec(dec), .busOff(busOff), .wakeIn(wakeIn), .ctrl(ctrl)
  );

  assign modeCfg    = ctrl.cfgOpen;
  assign modeNorm   = ctrl.inNorm;
  assign modeLoop   = ctrl.inLoop;
  assign modeSleep  = ctrl.inSleep;
  assign modeBusOff = ctrl.inBoff;

  // R2: exactly one mode output is active
  a_r2_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({modeCfg, modeNorm, modeLoop, modeSleep, modeBusOff}) == 1);

endmodule

// File: tb/tb_can_mode_ctrl.sv
`timescale 1ns/1ps
module tb_can_mode_ctrl;

  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  regAddr = 8'h18;
  logic [31:0] wrData = '0;
  logic        busOff = 1'b0;
  logic        wakeIn = 1'b0;
  logic [31:0] rdData;
  logic        modeCfg, modeNorm, modeLoop, modeSleep, modeBusOff;
  logic [7:0]  brpOut;
  logic [3:0]  tseg1Out;
  logic [2:0]  tseg2Out;
  logic [1:0]  sjwOut;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  can_mode_ctrl #(.START_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .busOff(busOff), .wakeIn(wakeIn),
    .modeCfg(modeCfg), .modeNorm(modeNorm), .modeLoop(modeLoop),
    .modeSleep(modeSleep), .modeBusOff(modeBusOff),
    .brpOut(brpOut), .tseg1Out(tseg1Out), .tseg2Out(tseg2Out), .sjwOut(sjwOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 cfg, 1 normal, 2 loopback, 3 sleep, 4 bus-off
  int       ms, mprior, mtarget, marm;
  bit       men;
  bit [1:0] mmsel;
  bit [7:0] mpresc;
  bit [8:0] mtime;

  function automatic logic [31:0] mstat();
    case (ms)
      0: return 32'h01;
      1: return 32'h08;
      2: return 32'h02;
      3: return 32'h04;
      default: return 32'h10;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return {30'b0, men, 1'b0};
      8'h04: return {30'b0, mmsel};
      8'h08: return {24'b0, mpresc};
      8'h0C: return {23'b0, mtime};
      8'h18: return mstat();
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int os;
    if (!rst_n) begin
      ms = 0; mprior = 1; mtarget = 1; marm = -1;
      men = 0; mmsel = 0; mpresc = 0; mtime = 0;
    end else begin
      os = ms;
      if (wrEn && regAddr == 8'h00 && wrData[0]) begin
        ms = 0; marm = -1;
      end else begin
        case (os)
          0: if (marm >= 0) begin
               if (marm == 0) begin ms = mtarget; marm = -1; end
               else marm--;
             end else if (wrEn && regAddr == 8'h00 && wrData[1]) begin
               marm = DLY - 1;
               mtarget = mmsel[1] ? 2 : 1;
             end
          1, 2: if (busOff) ms = 4;
                else if (wrEn && regAddr == 8'h04 && wrData[0]) begin mprior = os; ms = 3; end
          3: if (busOff) ms = 4; else if (wakeIn) ms = mprior;
          default: ;
        endcase
      end
      if (wrEn && regAddr == 8'h00) begin
        if (wrData[0]) begin men = 0; mmsel = 0; end
        else men = wrData[1];
      end
      if (wrEn && regAddr == 8'h04) mmsel = wrData[1:0];
      if (wrEn && regAddr == 8'h08 && os == 0) mpresc = wrData[7:0];
      if (wrEn && regAddr == 8'h0C && os == 0) mtime = wrData[8:0];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      chk("R10 readback vs model", rdData, mread(regAddr));
      chk("R2 mode outputs vs model",
          32'({modeBusOff, modeNorm, modeSleep, modeLoop, modeCfg}), mstat());
      chk("R3 prescaler vs model", 32'(brpOut), 32'(mpresc));
      chk("R3 timing fields vs model", 32'({sjwOut, tseg2Out, tseg1Out}), 32'(mtime));
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #5;
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk); #5;
    wrEn = 1'b0; regAddr = 8'h18; wrData = '0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    chk(tag, rdData, exp);
    regAddr = 8'h18;
  endtask

  task automatic pulseBus();
    @(posedge clk); #5; busOff = 1'b1;
    @(posedge clk); #5; busOff = 1'b0;
  endtask

  task automatic pulseWake();
    @(posedge clk); #5; wakeIn = 1'b1;
    @(posedge clk); #5; wakeIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    running = 1'b1;
    // R1 reset state
    rdchk("R1 status after reset", 8'h18, 32'h1);
    chk("R1 prescaler after reset", 32'(brpOut), 32'h0);
    chk("R1 config output", 32'(modeCfg), 32'h1);

    // R3 timing programming, with upper bits dropped
    wr(8'h08, 32'hFFFF_FFA5);
    wr(8'h0C, 32'hFFFF_FFD3);
    chk("R3 prescaler", 32'(brpOut), 32'hA5);
    chk("R3 segment 1", 32'(tseg1Out), 32'h3);
    chk("R3 segment 2", 32'(tseg2Out), 32'h5);
    chk("R3 jump width", 32'(sjwOut), 32'h3);
    rdchk("R10 timing readback masked", 8'h0C, 32'h1D3);

    // R5 start into normal after two clocks
    wr(8'h00, 32'h2);
    rdchk("R5 still config after edge 1", 8'h18, 32'h1);
    step();
    rdchk("R5 still config after edge 2-1", 8'h18, 32'h1);
    step();
    rdchk("R5 normal after two clocks", 8'h18, 32'h8);
    rdchk("R10 enable flag", 8'h00, 32'h2);

    // R4 timing locked outside configuration
    wr(8'h08, 32'h11);
    wr(8'h0C, 32'h0);
    chk("R4 prescaler unchanged", 32'(brpOut), 32'hA5);
    rdchk("R4 timing unchanged", 8'h0C, 32'h1D3);

    // R7 / R8 sleep and wake from normal
    wr(8'h04, 32'h1);
    rdchk("R7 sleep entered", 8'h18, 32'h4);
    pulseWake();
    rdchk("R8 back to normal", 8'h18, 32'h8);
    pulseWake();
    rdchk("R8 wake ignored in normal", 8'h18, 32'h8);

    // R9 bus-off and R6 recovery
    pulseBus();
    rdchk("R9 bus-off entered", 8'h18, 32'h10);
    wr(8'h00, 32'h2);
    step(); step(); step();
    rdchk("R9 enable ignored in bus-off", 8'h18, 32'h10);
    wr(8'h00, 32'h1);
    rdchk("R6 reset leaves bus-off", 8'h18, 32'h1);
    rdchk("R6 enable flag cleared", 8'h00, 32'h0);
    chk("R6 timing kept", 32'(brpOut), 32'hA5);
    pulseBus();
    rdchk("R9 bus-off ignored in config", 8'h18, 32'h1);

    // R5 loopback, then R8 wake returns to loopback, R9 from sleep
    wr(8'h04, 32'h2);
    rdchk("R10 mode select readback", 8'h04, 32'h2);
    wr(8'h00, 32'h2);
    step(); step();
    rdchk("R5 loopback after two clocks", 8'h18, 32'h2);
    wr(8'h04, 32'h3);
    rdchk("R7 sleep from loopback", 8'h18, 32'h4);
    pulseWake();
    rdchk("R8 back to loopback", 8'h18, 32'h2);
    wr(8'h04, 32'h3);
    pulseBus();
    rdchk("R9 bus-off from sleep", 8'h18, 32'h10);
    wr(8'h00, 32'h1);
    rdchk("R6 mode select cleared", 8'h04, 32'h0);

    // R6 reset wins over enable in the same write
    wr(8'h00, 32'h3);
    step(); step(); step();
    rdchk("R6 reset overrides enable", 8'h18, 32'h1);

    // R6 reset cancels a pending start
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    step(); step(); step();
    rdchk("R6 pending start cancelled", 8'h18, 32'h1);

    // R10 unmapped offset
    rdchk("R10 unmapped reads zero", 8'h10, 32'h0);

    step();
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule